// File: doc/BRIEF.md
# GPIB Controller-in-Charge Sequencer

This block holds the controller role of a GPIB interface. A processor drives it through three register accesses: a write strobe for the auxiliary command register, a write strobe for the single byte-output register, and a read strobe for the interrupt status register. The block keeps the controller state (never in charge, active, standby). It drives the ATN and IFC lines from that state. It also follows the talk and listen addresses it sends itself, so it knows whether it is currently the addressed talker or listener.

The bus side is simplified. A byte accepted from the processor is presented on `bus_byte` with `bus_valid` and a flag saying whether it went out under ATN (a command). It stays there until the bus returns a one-cycle `bus_accept`. Firmware paces its writes with the command-ready and data-ready status bits. Any write that arrives when neither bit allows it is refused and raises an error flag.

A two-stage reset synchronizer asserts the internal reset at once and releases it on the clock.

Top module: `gpib_cic_seq`

## Requirements
- R1: After reset, ATN, IFC, `bus_valid` and `bus_cmd` are low and the status register reads 0x00. The unit is then in the power-on hold and has never been controller-in-charge.
- R2: During the power-on hold, an auxiliary write of 0x00 ends the hold. Every other auxiliary code, and every byte-output write, has no effect during the hold: no state change, no error, nothing presented.
- R3: Auxiliary code 0x1E, outside the hold, drives IFC and ATN high and makes the unit controller-in-charge (status bit 7). It also drops any pending byte and clears the talker and listener roles.
- R4: Auxiliary code 0x16 drives IFC low and leaves the controller state and ATN unchanged. Auxiliary codes other than 0x00, 0x10, 0x11, 0x16 and 0x1E have no effect.
- R5: Auxiliary code 0x10 moves an active controller to standby and releases ATN. It has no effect on a unit that was never controller-in-charge, in standby, or while a byte is pending.
- R6: Auxiliary code 0x11 moves a standby controller back to active and raises ATN. It has no effect in any other state or while a byte is pending.
- R7: An accepted byte-output write is presented on `bus_byte` with `bus_valid` high one cycle later. `bus_cmd` equals ATN at the time of the write. The byte holds until the first cycle with `bus_accept` high, after which `bus_valid` falls. `bus_accept` with nothing pending is ignored.
- R8: Status bit 0 (command ready) is high exactly when ATN is high, the hold is over and no byte is pending. Status bit 1 (data ready) is high exactly when ATN is low, the unit is the addressed talker and no byte is pending.
- R9: A command byte whose top three bits are 010 is a talk address. It makes the unit the talker (status bit 5) when its low five bits equal `own_addr`, and clears the talker role otherwise.
- R10: A command byte whose top three bits are 001 and whose low five bits equal `own_addr` makes the unit a listener (status bit 6). The command byte 0x3F clears the listener role.
- R11: A byte-output write outside the hold, when neither ready bit is high, is refused: nothing is presented and status bit 2 (error) is set.
- R12: A status read returns the current bits. Bits 2, 3 and 4 clear on the following cycle unless the same event recurs in the read cycle; in that case the event wins. Bits 0, 1, 5, 6 and 7 are unaffected by reads.
- R13: Status bit 3 latches a rising edge of command ready and bit 4 latches a rising edge of data ready, each one cycle after the rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr | input | 5 | Bus address of this unit |
| aux_wr | input | 1 | Write strobe for the auxiliary command register |
| out_wr | input | 1 | Write strobe for the byte-output register |
| cpu_wdata | input | 8 | Write data for both registers |
| stat_rd | input | 1 | Read strobe for the status register |
| stat_rdata | output | 8 | Status register contents |
| atn | output | 1 | ATN line, active high |
| ifc | output | 1 | IFC line, active high |
| bus_byte | output | 8 | Byte presented to the bus |
| bus_valid | output | 1 | Byte on `bus_byte` awaits acceptance |
| bus_cmd | output | 1 | Presented byte was written under ATN |
| bus_accept | input | 1 | One-cycle acceptance of the presented byte |

## Verification
The bench takes the unit through the full bring-up order: hold release, 0x1E, 0x16, addressing, standby, data bytes, take-control and re-addressing. This shows that the command and data paths follow ATN. It then issues the state commands out of order: standby while never in charge, take-control while active, and either one with a byte pending. These runs separate correct state gating from commands that act unconditionally. Writes are issued while busy, under the wrong role and during the hold, which tells an error flag apart from a write that is silently ignored. Reads are placed in the same cycle as a ready-bit rise to check that a new event wins over the read clear. A long stretch of mixed random traffic is then compared against the reference model on every cycle.

// File: rtl/gpib_cic_pkg.sv
package gpib_cic_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 5;

  typedef enum logic [1:0] {
    CS_IDLE    = 2'd0,
    CS_ACTIVE  = 2'd1,
    CS_STANDBY = 2'd2
  } cic_state_t;

  // auxiliary command codes
  localparam logic [BYTE_W-1:0] AUX_CLR_POR = 8'h00;
  localparam logic [BYTE_W-1:0] AUX_IFC_ON  = 8'h1E;
  localparam logic [BYTE_W-1:0] AUX_IFC_OFF = 8'h16;
  localparam logic [BYTE_W-1:0] AUX_GTS     = 8'h10;
  localparam logic [BYTE_W-1:0] AUX_TCA     = 8'h11;

  // command byte groups (top three bits) and unlisten
  localparam logic [2:0] GRP_TALK   = 3'b010;
  localparam logic [2:0] GRP_LISTEN = 3'b001;
  localparam logic [BYTE_W-1:0] CMD_UNLISTEN = 8'h3F;

  // status register bit positions
  localparam int ST_CO     = 0;
  localparam int ST_DO     = 1;
  localparam int ST_ERR    = 2;
  localparam int ST_CO_EV  = 3;
  localparam int ST_DO_EV  = 4;
  localparam int ST_TALK   = 5;
  localparam int ST_LISTEN = 6;
  localparam int ST_CIC    = 7;

endpackage

// File: rtl/gpib_cic_rstsync.sv
module gpib_cic_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/gpib_cic_ctl.sv
module gpib_cic_ctl
  import gpib_cic_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          aux_wr,
  input  logic [DW-1:0] aux_code,
  input  logic          pend,
  output logic          por,
  output cic_state_t    state,
  output logic          ifc_o,
  output logic          atn_o,
  output logic          ifc_hit
);

  logic       por_q, por_d;
  cic_state_t st_q, st_d;
  logic       ifc_q, ifc_d;
  logic       en;

  // next state
  always_comb begin
    por_d   = por_q;
    st_d    = st_q;
    ifc_d   = ifc_q;
    ifc_hit = 1'b0;
    if (aux_wr) begin
      if (por_q) begin
        if (aux_code == AUX_CLR_POR) por_d = 1'b0;
      end else begin
        unique case (aux_code)
          AUX_IFC_ON: begin
            ifc_d   = 1'b1;
            st_d    = CS_ACTIVE;
            ifc_hit = 1'b1;
          end
          AUX_IFC_OFF: ifc_d = 1'b0;
          AUX_GTS: if (st_q == CS_ACTIVE && !pend) st_d = CS_STANDBY;
          AUX_TCA: if (st_q == CS_STANDBY && !pend) st_d = CS_ACTIVE;
          default: ;
        endcase
      end
    end
  end

  assign en = aux_wr;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_q <= 1'b1;
      st_q  <= CS_IDLE;
      ifc_q <= 1'b0;
    end else if (en) begin
      por_q <= por_d;
      st_q  <= st_d;
      ifc_q <= ifc_d;
    end
  end

  assign por   = por_q;
  assign state = st_q;
  assign ifc_o = ifc_q;
  assign atn_o = (st_q == CS_ACTIVE);

  // R5: standby request never lifts a unit that was never in charge
  a_r5_gts_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_wr && aux_code == AUX_GTS && st_q == CS_IDLE) |=> (st_q == CS_IDLE));

  // R3: IFC command gives IFC and ATN
  a_r3_ifc_cic: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_wr && !por_q && aux_code == AUX_IFC_ON) |=> (ifc_o && atn_o));

  // R2: hold keeps the unit idle until the release code
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (por_q && !(aux_wr && aux_code == AUX_CLR_POR)) |=> (por_q && st_q == CS_IDLE && !ifc_q));

  // R6: take-control leaves an active unit active
  a_r6_tca_active: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_wr && aux_code == AUX_TCA && st_q == CS_ACTIVE) |=> atn_o);

endmodule

// File: rtl/gpib_cic_out.sv
module gpib_cic_out
  import gpib_cic_pkg::*;
#(
  parameter int DW = BYTE_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          out_wr,
  input  logic [DW-1:0] out_data,
  input  logic [AW-1:0] own_addr,
  input  logic          por,
  input  logic          atn,
  input  logic          ifc_hit,
  input  logic          bus_accept,
  output logic          bus_valid,
  output logic [DW-1:0] bus_byte,
  output logic          bus_cmd,
  output logic          talker,
  output logic          listener,
  output logic          co_rdy,
  output logic          do_rdy,
  output logic          wr_err
);

  localparam int GRP_LSB = AW;

  logic          busy_q, busy_d;
  logic [DW-1:0] byte_q;
  logic          cmd_q;
  logic          talk_q, talk_d;
  logic          lis_q, lis_d;
  logic          ok_cmd, ok_dat, load;
  logic [2:0]    grp;
  logic [AW-1:0] addr_f;

  assign co_rdy = !por && atn && !busy_q;
  assign do_rdy = !por && !atn && talk_q && !busy_q;
  assign ok_cmd = out_wr && co_rdy;
  assign ok_dat = out_wr && do_rdy;
  assign load   = (ok_cmd || ok_dat) && !ifc_hit;
  assign wr_err = out_wr && !por && !co_rdy && !do_rdy;
  assign grp    = out_data[GRP_LSB +: 3];
  assign addr_f = out_data[AW-1:0];

  // next state
  always_comb begin
    busy_d = busy_q;
    talk_d = talk_q;
    lis_d  = lis_q;
    if (ifc_hit) begin
      busy_d = 1'b0;
      talk_d = 1'b0;
      lis_d  = 1'b0;
    end else begin
      if (load)                       busy_d = 1'b1;
      else if (busy_q && bus_accept)  busy_d = 1'b0;
      if (ok_cmd) begin
        if (grp == GRP_TALK) talk_d = (addr_f == own_addr);
        if (out_data == CMD_UNLISTEN) lis_d = 1'b0;
        else if (grp == GRP_LISTEN && addr_f == own_addr) lis_d = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      talk_q <= 1'b0;
      lis_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      talk_q <= talk_d;
      lis_q  <= lis_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      cmd_q  <= 1'b0;
    end else if (load) begin
      byte_q <= out_data;
      cmd_q  <= ok_cmd;
    end
  end

  assign bus_valid = busy_q;
  assign bus_byte  = byte_q;
  assign bus_cmd   = cmd_q;
  assign talker    = talk_q;
  assign listener  = lis_q;

  // R7: presented byte holds until accepted
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_accept && !ifc_hit) |=> (bus_valid && $stable(bus_byte)));

  // R8: command-ready and data-ready never together
  a_r8_excl: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> !(co_rdy && do_rdy));

  // R11: refused write presents nothing
  a_r11_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_err && !bus_valid) |=> !bus_valid);

  // R7: accepted write is presented next cycle
  a_r7_present: assert property (@(posedge clk) disable iff (!rst_n)
    (load) |=> (bus_valid && bus_byte == $past(out_data)));

endmodule

// File: rtl/gpib_cic_isr.sv
module gpib_cic_isr
  import gpib_cic_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  logic          co_rdy,
  input  logic          do_rdy,
  input  logic          err_set,
  input  logic          talker,
  input  logic          listener,
  input  logic          cic,
  output logic [DW-1:0] status
);

  logic err_q, err_d;
  logic cor_q, cor_d;
  logic dor_q, dor_d;
  logic co_prev_q, do_prev_q;
  logic co_rise, do_rise;

  assign co_rise = co_rdy && !co_prev_q;
  assign do_rise = do_rdy && !do_prev_q;

  // next state: read clears, a new event wins
  always_comb begin
    err_d = (rd ? 1'b0 : err_q) | err_set;
    cor_d = (rd ? 1'b0 : cor_q) | co_rise;
    dor_d = (rd ? 1'b0 : dor_q) | do_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q     <= 1'b0;
      cor_q     <= 1'b0;
      dor_q     <= 1'b0;
      co_prev_q <= 1'b0;
      do_prev_q <= 1'b0;
    end else begin
      err_q     <= err_d;
      cor_q     <= cor_d;
      dor_q     <= dor_d;
      co_prev_q <= co_rdy;
      do_prev_q <= do_rdy;
    end
  end

  always_comb begin
    status             = '0;
    status[ST_CO]      = co_rdy;
    status[ST_DO]      = do_rdy;
    status[ST_ERR]     = err_q;
    status[ST_CO_EV]   = cor_q;
    status[ST_DO_EV]   = dor_q;
    status[ST_TALK]    = talker;
    status[ST_LISTEN]  = listener;
    status[ST_CIC]     = cic;
  end

  // R12: read without a new error clears the error flag
  a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !err_set) |=> !err_q);

  // R13: a rise of command-ready is latched
  a_r13_co_ev: assert property (@(posedge clk) disable iff (!rst_n)
    (co_rdy && !co_prev_q) |=> cor_q);

  // R11: refused write raises the error flag
  a_r11_err: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> err_q);

endmodule

// File: rtl/gpib_cic_seq.sv
module gpib_cic_seq
  import gpib_cic_pkg::*;
#(
  parameter int DW = BYTE_W,
  parameter int AW = ADDR_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] own_addr,
  input  logic          aux_wr,
  input  logic          out_wr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          stat_rd,
  output logic [DW-1:0] stat_rdata,
  output logic          atn,
  output logic          ifc,
  output logic [DW-1:0] bus_byte,
  output logic          bus_valid,
  output logic          bus_cmd,
  input  logic          bus_accept
);

  logic       rst_i;
  logic       por;
  cic_state_t state;
  logic       ifc_hit;
  logic       talker, listener, co_rdy, do_rdy, wr_err;

  gpib_cic_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_i)
  );

  gpib_cic_ctl #(.DW(DW)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_i),
    .aux_wr   (aux_wr),
    .aux_code (cpu_wdata),
    .pend     (bus_valid),
    .por      (por),
    .state    (state),
    .ifc_o    (ifc),
    .atn_o    (atn),
    .ifc_hit  (ifc_hit)
  );

  gpib_cic_out #(.DW(DW), .AW(AW)) u_out (
    .clk        (clk),
    .rst_n      (rst_i),
    .out_wr     (out_wr),
    .out_data   (cpu_wdata),
    .own_addr   (own_addr),
    .por        (por),
    .atn        (atn),
    .ifc_hit    (ifc_hit),
    .bus_accept (bus_accept),
    .bus_valid  (bus_valid),
    .bus_byte   (bus_byte),
    .bus_cmd    (bus_cmd),
    .talker     (talker),
    .listener   (listener),
    .co_rdy     (co_rdy),
    .do_rdy     (do_rdy),
    .wr_err     (wr_err)
  );

  gpib_cic_isr #(.DW(DW)) u_isr (
    .clk      (clk),
    .rst_n    (rst_i),
    .rd       (stat_rd),
    .co_rdy   (co_rdy),
    .do_rdy   (do_rdy),
    .err_set  (wr_err),
    .talker   (talker),
    .listener (listener),
    .cic      (state != CS_IDLE),
    .status   (stat_rdata)
  );

  // R1: out of reset nothing is driven
  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(rst_i) |-> (!atn && !ifc && !bus_valid));

endmodule

// File: tb/gpib_cic_seq_test.sv
module gpib_cic_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] OWN = 5'd5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       aux_wr = 1'b0, out_wr = 1'b0, stat_rd = 1'b0, bus_accept = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] stat_rdata, bus_byte;
  logic       atn, ifc, bus_valid, bus_cmd;

  int vectors = 0;
  int miscompares = 0;
  string phase = "R1";

  // reference model state
  bit         m_por = 1, m_ifc = 0, m_busy = 0, m_cmd = 0, m_talk = 0, m_lis = 0;
  bit         m_err = 0, m_cor = 0, m_dor = 0, m_cop = 0, m_dop = 0;
  int         m_st = 0;  // 0 never in charge, 1 active, 2 standby
  logic [7:0] m_byte = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpib_cic_seq uut (
    .clk(clk), .rst_n(rst_n), .own_addr(OWN), .aux_wr(aux_wr), .out_wr(out_wr),
    .cpu_wdata(cpu_wdata), .stat_rd(stat_rd), .stat_rdata(stat_rdata),
    .atn(atn), .ifc(ifc), .bus_byte(bus_byte), .bus_valid(bus_valid),
    .bus_cmd(bus_cmd), .bus_accept(bus_accept)
  );

  function automatic bit m_co();
    return !m_por && m_st == 1 && !m_busy;
  endfunction
  function automatic bit m_do();
    return !m_por && m_st != 1 && m_talk && !m_busy;
  endfunction
  function automatic logic [7:0] m_status();
    return {m_st != 0, m_lis, m_talk, m_dor, m_cor, m_err, m_do(), m_co()};
  endfunction

  task automatic model_edge();
    bit co, dq, okc, okd, bad, hit, pre_busy;
    if (!rst_n) begin
      m_por = 1; m_ifc = 0; m_busy = 0; m_cmd = 0; m_talk = 0; m_lis = 0;
      m_err = 0; m_cor = 0; m_dor = 0; m_cop = 0; m_dop = 0; m_st = 0; m_byte = 0;
      return;
    end
    co = m_co(); dq = m_do(); pre_busy = m_busy;
    okc = out_wr && co; okd = out_wr && dq;
    bad = out_wr && !m_por && !co && !dq;
    hit = aux_wr && !m_por && cpu_wdata == 8'h1E;
    m_err = (stat_rd ? 0 : m_err) | bad;
    m_cor = (stat_rd ? 0 : m_cor) | (co && !m_cop);
    m_dor = (stat_rd ? 0 : m_dor) | (dq && !m_dop);
    m_cop = co; m_dop = dq;
    if (hit) begin
      m_busy = 0; m_talk = 0; m_lis = 0;
    end else begin
      if (okc || okd) begin
        m_busy = 1; m_byte = cpu_wdata; m_cmd = okc;
      end else if (m_busy && bus_accept) m_busy = 0;
      if (okc) begin
        if (cpu_wdata[7:5] == 3'b010) m_talk = (cpu_wdata[4:0] == OWN);
        if (cpu_wdata == 8'h3F) m_lis = 0;
        else if (cpu_wdata[7:5] == 3'b001 && cpu_wdata[4:0] == OWN) m_lis = 1;
      end
    end
    if (aux_wr) begin
      if (m_por) begin
        if (cpu_wdata == 8'h00) m_por = 0;
      end else begin
        case (cpu_wdata)
          8'h1E: begin m_ifc = 1; m_st = 1; end
          8'h16: m_ifc = 0;
          8'h10: if (m_st == 1 && !pre_busy) m_st = 2;
          8'h11: if (m_st == 2 && !pre_busy) m_st = 1;
          default: ;
        endcase
      end
    end
  endtask

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %02h expected %02h at %0t", phase, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    vectors++;
    chk("atn", {7'd0, atn}, {7'd0, m_st == 1});
    chk("ifc", {7'd0, ifc}, {7'd0, m_ifc});
    chk("bus_valid", {7'd0, bus_valid}, {7'd0, m_busy});
    chk("bus_cmd", {7'd0, bus_cmd}, {7'd0, m_cmd});
    chk("bus_byte", bus_byte, m_byte);
    chk("status", stat_rdata, m_status());
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    aux_wr = 0; out_wr = 0; stat_rd = 0; bus_accept = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask
  task automatic aux(logic [7:0] c);
    aux_wr = 1; cpu_wdata = c; cyc();
  endtask
  task automatic wr(logic [7:0] b);
    out_wr = 1; cpu_wdata = b; cyc();
  endtask
  task automatic acc();
    bus_accept = 1; cyc();
  endtask
  task automatic rd();
    stat_rd = 1; cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk);
    phase = "R1"; idle(3);
    rst_n = 1; idle(4);
    chk("R1 reset status", stat_rdata, 8'h00);

    phase = "R2"; aux(8'h1E); aux(8'h10); wr(8'h45); idle(2);
    chk("R2 hold status", stat_rdata, 8'h00);
    aux(8'h00); idle(1);

    phase = "R5"; aux(8'h10); idle(1);
    phase = "R6"; aux(8'h11); idle(1);
    chk("R5/R6 idle cic bit", stat_rdata, 8'h00);

    phase = "R3"; aux(8'h1E); idle(2);
    phase = "R4"; aux(8'h16); aux(8'h5A); idle(1);
    phase = "R13"; rd(); idle(1);

    phase = "R7"; wr(8'h45); idle(3); acc(); acc();
    phase = "R11"; wr(8'h25); wr(8'h3F); idle(1); rd();
    phase = "R10"; acc(); wr(8'h25); acc(); idle(1);
    chk("R10 listener bit", {7'd0, stat_rdata[6]}, 8'h01);
    wr(8'h3F); acc();
    phase = "R9"; wr(8'h40); idle(1);
    phase = "R5"; aux(8'h10); acc(); idle(1);
    phase = "R9"; wr(8'h45); acc(); idle(1);
    chk("R9 talker bit", {7'd0, stat_rdata[5]}, 8'h01);

    phase = "R5"; aux(8'h10); idle(2);
    phase = "R8"; wr(8'h2A); acc(); wr(8'h49); idle(1);
    phase = "R6"; aux(8'h11); acc();
    phase = "R12"; rd(); rd();
    phase = "R8"; wr(8'h44); bus_accept = 1; stat_rd = 1; cyc(); idle(2);
    phase = "R6"; aux(8'h11); idle(1);
    phase = "R9"; wr(8'h4A); acc(); aux(8'h10); idle(1);
    phase = "R11"; wr(8'h4E); idle(1); rd(); idle(1);
    phase = "R3"; aux(8'h11); wr(8'h45); aux(8'h1E); idle(2);

    phase = "R12";
    for (int i = 0; i < 2000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      case (r)
        0: begin aux_wr = 1; cpu_wdata = 8'h10; end
        1: begin aux_wr = 1; cpu_wdata = 8'h11; end
        2: begin aux_wr = 1; cpu_wdata = ($urandom_range(0, 7) == 0) ? 8'h1E : 8'h16; end
        3, 4: begin out_wr = 1;
          cpu_wdata = ($urandom_range(0, 1) == 1) ?
                      {3'b010, ($urandom_range(0, 1) == 1) ? OWN : 5'(($urandom_range(0, 30)))} :
                      8'($urandom_range(0, 255)); end
        5: begin out_wr = 1; cpu_wdata = {3'b001, ($urandom_range(0, 1) == 1) ? OWN : 5'd3}; end
        default: ;
      endcase
      bus_accept = ($urandom_range(0, 2) == 0);
      stat_rd = ($urandom_range(0, 3) == 0);
      cyc();
    end

    phase = "R1"; rst_n = 0; idle(2);
    chk("R1 mid-run reset status", stat_rdata, 8'h00);
    rst_n = 1; idle(4);
    phase = "R2"; wr(8'h41); idle(1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule